// File: doc/BRIEF.md
# Interlace-Aware Capture Line Address Generator

This block produces the base address in memory of every image line written during capture. Software supplies a 32-bit start address as two 16-bit halves, a line pitch in units of 32 bytes, and a set of step codes. After each re-initialisation the block holds the address of the line being captured. Each line strobe moves it to the address of the next line. The move is a signed multiple of the pitch, and it can point up or down through memory.

The step is taken from one of four 3-bit codes. The code is chosen by the field the frame belongs to and by whether the current line is even or odd. This lets two interlaced fields either interleave into one frame buffer or stay in separate regions. A field whose ID is 1 can also begin a programmable number of lines into the buffer. The incoming field ID can be inverted. Re-initialisation comes from the frame-start strobe. If external triggering is enabled, it comes instead from a rising edge of either the write-enable input or the field-ID input.

Control is a two-state machine. ST_IDLE is entered at reset, and in it line strobes are ignored. ST_RUN is the state in which lines are stepped. The transitions are: T_ARM (ST_IDLE to ST_RUN on a reload event), T_REARM (ST_RUN to ST_RUN on a reload event, which restarts the frame), T_STEP (ST_RUN to ST_RUN on a line strobe with no reload) and T_HOLD (remain in the state when there is neither).

Top module: `ilace_line_addr`

## Requirements
- R1: After reset `line_addr` is 0 and `addr_live` is 0. Line strobes given before the first reload event leave `line_addr` unchanged.
- R2: With `trig_en`=0, a `frame_start` strobe is a reload event. If the effective field is 0, `line_addr` equals {`start_hi`,`start_lo`} in the next cycle, and `addr_live` becomes 1 and stays 1.
- R3: At a reload event with effective field 1, `line_addr` becomes the start address plus (`field1_lead`+1) × `pitch` × 32 bytes, or minus that amount when `dir_down`=1.
- R4: In ST_RUN each `line_start` without a reload adds N × `pitch` × 32 to `line_addr` in the next cycle. The selected 3-bit code c gives N = c+1 for c in 0..3 and N = −(c−3) for c in 4..7. The code is `step_e0` for an even line in field 0, `step_o0` for an odd line in field 0, `step_e1` for an even line in field 1 and `step_o1` for an odd line in field 1.
- R5: `dir_down`=1 negates every step and the field-1 lead offset. All address arithmetic wraps modulo 2^32.
- R6: Line parity is even at each reload event and toggles on every stepped line.
- R7: The effective field is `fid_in` XOR `fid_invert`. It is latched at the reload event, so changes of `fid_in` during the frame do not alter the step selection.
- R8: With `trig_en`=1, `frame_start` has no effect. The reload event is then a rising edge of `wen` (`trig_sel`=0) or of the effective field (`trig_sel`=1). A rising edge means the input is sampled high when it was low in the previous cycle, and that previous value is 0 after reset.
- R9: When a reload event and `line_start` fall in the same cycle, the reload wins and no step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_hi | input | 16 | Upper half of the start address |
| start_lo | input | 16 | Lower half of the start address |
| pitch | input | 12 | Line pitch in 32-byte units |
| dir_down | input | 1 | 1: lines run toward lower addresses |
| fid_invert | input | 1 | Inverts the field ID |
| step_e0 | input | 3 | Step code, even line, field 0 |
| step_o0 | input | 3 | Step code, odd line, field 0 |
| step_e1 | input | 3 | Step code, even line, field 1 |
| step_o1 | input | 3 | Step code, odd line, field 1 |
| field1_lead | input | 2 | Field-1 start offset, 1 to 4 lines |
| trig_en | input | 1 | Enables external trigger re-initialisation |
| trig_sel | input | 1 | Trigger source: 0 write-enable, 1 field ID |
| wen | input | 1 | Write-enable input |
| fid_in | input | 1 | Field ID input |
| frame_start | input | 1 | Frame-start strobe |
| line_start | input | 1 | Line strobe |
| line_addr | output | 32 | Base address of the current line |
| addr_live | output | 1 | Set once the first reload event has occurred |

## Verification
Four properties are checked on every cycle:
- the address is held while the block is idle;
- a field-0 reload lands exactly on the start address;
- `frame_start` is ignored under triggering, and the live flag is sticky once set;
- a stepped line always moves the address when the pitch is non-zero, and never moves it when the pitch is zero.

The bench's directed scenarios are the only check on the signed step magnitudes, the parity and field selection of the codes, the field-1 lead, the inversion and latching of the field ID, the wrap in the downward direction, and the priority of a reload over a line strobe in the same cycle.

// File: rtl/lag_pkg.sv
package lag_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lag_state_e;

    // Signed number of lines encoded by a 3-bit step code.
    function automatic logic signed [3:0] code_to_lines(input logic [2:0] code);
        logic signed [3:0] n;
        if (code[2] == 1'b0) n = $signed({2'b00, code[1:0]}) + 4'sd1;
        else                 n = -($signed({2'b00, code[1:0]}) + 4'sd1);
        return n;
    endfunction
endpackage

// File: rtl/lag_step_sel.sv
module lag_step_sel
    import lag_pkg::*;
(
    input  logic [2:0]        code_e0,
    input  logic [2:0]        code_o0,
    input  logic [2:0]        code_e1,
    input  logic [2:0]        code_o1,
    input  logic              field,
    input  logic              odd_line,
    output logic signed [3:0] lines
);
    logic [2:0] table_q [4];
    logic [2:0] picked;

    always_comb begin
        table_q[0] = code_e0;
        table_q[1] = code_o0;
        table_q[2] = code_e1;
        table_q[3] = code_o1;
        picked     = table_q[{field, odd_line}];
        lines      = code_to_lines(picked);
    end
endmodule

// File: rtl/lag_offset_mul.sv
module lag_offset_mul #(
    parameter int ADDR_W     = 32,
    parameter int PITCH_W    = 12,
    parameter int UNIT_SHIFT = 5
) (
    input  logic signed [3:0]   lines,
    input  logic [PITCH_W-1:0]  pitch,
    input  logic                down,
    output logic [ADDR_W-1:0]   delta
);
    localparam int PW = PITCH_W + 3 + UNIT_SHIFT;

    logic [2:0]        mag;
    logic [PW-1:0]     prod;
    logic [ADDR_W-1:0] ext;
    logic              neg;

    always_comb begin
        mag   = lines[3] ? 3'(-lines) : lines[2:0];
        prod  = (PW'(pitch) * PW'(mag)) << UNIT_SHIFT;
        ext   = ADDR_W'(prod);
        neg   = lines[3] ^ down;
        delta = neg ? (~ext + 1'b1) : ext;
    end
endmodule

// File: rtl/lag_reinit.sv
module lag_reinit (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_en,
    input  logic trig_sel,
    input  logic wen,
    input  logic fid_eff,
    input  logic frame_start,
    output logic reload
);
    logic wen_q;
    logic fid_q;
    logic src_rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q <= 1'b0;
            fid_q <= 1'b0;
        end else begin
            wen_q <= wen;
            fid_q <= fid_eff;
        end
    end

    always_comb begin
        src_rise = trig_sel ? (fid_eff & ~fid_q) : (wen & ~wen_q);
        reload   = trig_en ? src_rise : frame_start;
    end
endmodule

// File: rtl/ilace_line_addr.sv
module ilace_line_addr
    import lag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int HALF_W     = 16,
    parameter int PITCH_W    = 12,
    parameter int UNIT_SHIFT = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HALF_W-1:0]  start_hi,
    input  logic [HALF_W-1:0]  start_lo,
    input  logic [PITCH_W-1:0] pitch,
    input  logic               dir_down,
    input  logic               fid_invert,
    input  logic [2:0]         step_e0,
    input  logic [2:0]         step_o0,
    input  logic [2:0]         step_e1,
    input  logic [2:0]         step_o1,
    input  logic [1:0]         field1_lead,
    input  logic               trig_en,
    input  logic               trig_sel,
    input  logic               wen,
    input  logic               fid_in,
    input  logic               frame_start,
    input  logic               line_start,
    output logic [ADDR_W-1:0]  line_addr,
    output logic               addr_live
);
    lag_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic              fld_q;
    logic              odd_q;
    logic              fid_eff;
    logic              reload_evt;
    logic              do_step;
    logic signed [3:0] step_lines;
    logic signed [3:0] lead_lines;
    logic [ADDR_W-1:0] step_delta;
    logic [ADDR_W-1:0] lead_delta;
    logic [ADDR_W-1:0] start_addr;

    assign fid_eff    = fid_in ^ fid_invert;
    assign start_addr = ADDR_W'({start_hi, start_lo});
    assign lead_lines = $signed({2'b00, field1_lead}) + 4'sd1;

    lag_reinit u_reinit (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_en     (trig_en),
        .trig_sel    (trig_sel),
        .wen         (wen),
        .fid_eff     (fid_eff),
        .frame_start (frame_start),
        .reload      (reload_evt)
    );

    lag_step_sel u_sel (
        .code_e0  (step_e0),
        .code_o0  (step_o0),
        .code_e1  (step_e1),
        .code_o1  (step_o1),
        .field    (fld_q),
        .odd_line (odd_q),
        .lines    (step_lines)
    );

    lag_offset_mul #(
        .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .UNIT_SHIFT(UNIT_SHIFT)
    ) u_step_mul (
        .lines (step_lines),
        .pitch (pitch),
        .down  (dir_down),
        .delta (step_delta)
    );

    lag_offset_mul #(
        .ADDR_W(ADDR_W), .PITCH_W(PITCH_W), .UNIT_SHIFT(UNIT_SHIFT)
    ) u_lead_mul (
        .lines (lead_lines),
        .pitch (pitch),
        .down  (dir_down),
        .delta (lead_delta)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: T_ARM, T_REARM, T_STEP, T_HOLD
    always_comb begin
        state_d = state_q;
        do_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (reload_evt) state_d = ST_RUN;            // T_ARM
            end
            ST_RUN: begin
                if (reload_evt) state_d = ST_RUN;            // T_REARM
                else if (line_start) do_step = 1'b1;         // T_STEP
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output / datapath process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            fld_q  <= 1'b0;
            odd_q  <= 1'b0;
        end else if (reload_evt) begin
            addr_q <= fid_eff ? (start_addr + lead_delta) : start_addr;
            fld_q  <= fid_eff;
            odd_q  <= 1'b0;
        end else if (do_step) begin
            addr_q <= addr_q + step_delta;
            odd_q  <= ~odd_q;
        end
    end

    assign line_addr = addr_q;
    assign addr_live = (state_q == ST_RUN);
endmodule

// File: rtl/ilace_line_addr_chk.sv
module ilace_line_addr_chk #(
    parameter int ADDR_W  = 32,
    parameter int HALF_W  = 16,
    parameter int PITCH_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HALF_W-1:0]  start_hi,
    input logic [HALF_W-1:0]  start_lo,
    input logic [PITCH_W-1:0] pitch,
    input logic               trig_en,
    input logic               frame_start,
    input logic               line_start,
    input logic               fid_eff,
    input logic               reload_evt,
    input logic [ADDR_W-1:0]  line_addr,
    input logic               addr_live
);
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_live && !reload_evt) |=> $stable(line_addr));                      // R1

    AST_RELOAD_F0: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_evt && !fid_eff) |=> (line_addr == ADDR_W'($past({start_hi, start_lo})))); // R2

    AST_LIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_live || reload_evt) |=> addr_live);                                 // R2

    AST_TRIG_FRAME_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_en && frame_start && !reload_evt && !line_start) |=> $stable(line_addr)); // R8

    AST_LINE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_live && line_start && !reload_evt && pitch != '0)
        |=> (line_addr != $past(line_addr)));                                     // R4

    AST_ZERO_PITCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_live && line_start && !reload_evt && pitch == '0) |=> $stable(line_addr)); // R4
endmodule

bind ilace_line_addr ilace_line_addr_chk #(
    .ADDR_W(ADDR_W), .HALF_W(HALF_W), .PITCH_W(PITCH_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_hi    (start_hi),
    .start_lo    (start_lo),
    .pitch       (pitch),
    .trig_en     (trig_en),
    .frame_start (frame_start),
    .line_start  (line_start),
    .fid_eff     (fid_eff),
    .reload_evt  (reload_evt),
    .line_addr   (line_addr),
    .addr_live   (addr_live)
);

// File: tb/ilace_line_addr_tb.sv
`timescale 1ns/1ps
module ilace_line_addr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] start_hi = '0, start_lo = '0;
    logic [11:0] pitch = '0;
    logic        dir_down = 0, fid_invert = 0;
    logic [2:0]  step_e0 = 0, step_o0 = 0, step_e1 = 0, step_o1 = 0;
    logic [1:0]  field1_lead = 0;
    logic        trig_en = 0, trig_sel = 0, wen = 0, fid_in = 0;
    logic        frame_start = 0, line_start = 0;
    logic [31:0] line_addr;
    logic        addr_live;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Bench model state
    logic [31:0] e_addr = '0;
    bit e_par = 0, e_fld = 0, e_live = 0;

    always #4 clk = ~clk;

    ilace_line_addr u_dut (
        .clk(clk), .rst_n(rst_n), .start_hi(start_hi), .start_lo(start_lo),
        .pitch(pitch), .dir_down(dir_down), .fid_invert(fid_invert),
        .step_e0(step_e0), .step_o0(step_o0), .step_e1(step_e1), .step_o1(step_o1),
        .field1_lead(field1_lead), .trig_en(trig_en), .trig_sel(trig_sel),
        .wen(wen), .fid_in(fid_in), .frame_start(frame_start),
        .line_start(line_start), .line_addr(line_addr), .addr_live(addr_live)
    );

    function automatic int code_lines(input logic [2:0] c);
        if (c < 3'd4) return int'(c) + 1;
        return -(int'(c) - 3);
    endfunction

    function automatic logic [31:0] bytes_for(input int n);
        logic [31:0] m;
        m = 32'(n * int'(pitch) * 32);
        return dir_down ? (32'd0 - m) : m;
    endfunction

    task automatic m_reload(input bit f);
        e_addr = {start_hi, start_lo} + (f ? bytes_for(int'(field1_lead) + 1) : 32'd0);
        e_fld  = f;
        e_par  = 0;
        e_live = 1;
    endtask

    task automatic m_line();
        logic [2:0] c;
        if (!e_live) return;
        case ({e_fld, e_par})
            2'b00: c = step_e0;
            2'b01: c = step_o0;
            2'b10: c = step_e1;
            default: c = step_o1;
        endcase
        e_addr = e_addr + bytes_for(code_lines(c));
        e_par  = ~e_par;
    endtask

    task automatic check(input string req);
        total++;
        if (line_addr !== e_addr || addr_live !== e_live) begin
            bad++;
            $display("FAIL %s: addr=%h live=%0d expected addr=%h live=%0d",
                     req, line_addr, addr_live, e_addr, e_live);
        end
    endtask

    task automatic pulse_frame();
        @(negedge clk) frame_start = 1;
        @(negedge clk) frame_start = 0;
        if (!trig_en) m_reload(fid_in ^ fid_invert);
    endtask

    task automatic pulse_line();
        @(negedge clk) line_start = 1;
        @(negedge clk) line_start = 0;
        m_line();
    endtask

    task automatic t_reset();
        check("R1 reset");
        pulse_line();
        check("R1 line ignored in idle");
    endtask

    task automatic t_progressive();
        start_hi = 16'h1000; start_lo = 16'h0040; pitch = 12'd10;
        step_e0 = 3'd0; step_o0 = 3'd1; fid_in = 0;
        pulse_frame();
        check("R2 reload field0");
        for (int i = 0; i < 3; i++) begin
            pulse_line();
            check("R4 step field0");
        end
    endtask

    task automatic t_weave();
        fid_in = 1; field1_lead = 2'd2; step_e1 = 3'd1; step_o1 = 3'd3;
        pulse_frame();
        check("R3 field1 lead");
        pulse_line(); check("R4 step e1");
        pulse_line(); check("R4 step o1");
        pulse_line(); check("R6 parity toggles");
        fid_in = 0; step_e0 = 3'd2; step_o0 = 3'd0;
        pulse_frame();
        pulse_line(); check("R6 parity even after reload");
    endtask

    task automatic t_negative();
        fid_in = 0; step_e0 = 3'd4; step_o0 = 3'd7; pitch = 12'd100;
        start_hi = 16'h0002; start_lo = 16'h0000;
        pulse_frame();
        pulse_line(); check("R4 code4 minus1");
        pulse_line(); check("R4 code7 minus4");
    endtask

    task automatic t_down();
        dir_down = 1; start_hi = 16'h0000; start_lo = 16'h0010;
        step_e0 = 3'd0; step_o0 = 3'd5; pitch = 12'd1;
        pulse_frame();
        pulse_line(); check("R5 down wraps");
        pulse_line(); check("R5 down negative code");
        fid_in = 1; field1_lead = 2'd3;
        pulse_frame(); check("R5 lead downward");
        dir_down = 0; fid_in = 0;
    endtask

    task automatic t_invert();
        fid_invert = 1; fid_in = 0; field1_lead = 2'd0;
        start_hi = 16'h0100; start_lo = 16'h0000; pitch = 12'd8;
        step_e0 = 3'd0; step_o0 = 3'd0; step_e1 = 3'd3; step_o1 = 3'd3;
        pulse_frame(); check("R7 inverted field");
        @(negedge clk) fid_in = 1;
        pulse_line(); check("R7 field latched");
        fid_invert = 0; fid_in = 0;
    endtask

    task automatic t_trig_wen();
        trig_en = 1; trig_sel = 0; start_hi = 16'h0300; start_lo = 16'h0000;
        pulse_frame(); check("R8 frame ignored");
        @(negedge clk) wen = 1;
        m_reload(fid_in ^ fid_invert);
        @(negedge clk); check("R8 wen rise reload");
        pulse_line();
        check("R8 high wen no reload");
        @(negedge clk) wen = 0;
    endtask

    task automatic t_trig_fid();
        trig_sel = 1; start_hi = 16'h0400; field1_lead = 2'd1;
        @(negedge clk) fid_in = 1;
        m_reload(1);
        @(negedge clk); check("R8 fid rise reload");
        @(negedge clk) fid_in = 0;
        trig_en = 0; trig_sel = 0;
    endtask

    task automatic t_collide();
        start_hi = 16'h0500; start_lo = 16'h0020;
        pulse_line();
        @(negedge clk) begin frame_start = 1; line_start = 1; end
        @(negedge clk) begin frame_start = 0; line_start = 0; end
        m_reload(fid_in ^ fid_invert);
        check("R9 reload beats line");
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_progressive();
        t_weave();
        t_negative();
        t_down();
        t_invert();
        t_trig_wen();
        t_trig_fid();
        t_collide();
        done = 1;
        summary();
    end
endmodule